// File: doc/BRIEF.md
# Progressive-to-Interlaced 4:2:2 Byte-Stream Formatter

The formatter accepts a non-interlaced stream of 24-bit RGB pixels with line and frame markers. It converts each pixel to YCbCr with fixed-point studio-range coefficients, halves the chroma rate by averaging each pixel pair, and serialises the result as an 8-bit multiplexed byte stream with a byte strobe. Every emitted line is framed by a start-of-active-video code at its beginning and an end-of-active-video code after its last pixel, followed by a run of blanking fill.

In interlaced mode each source frame becomes one field. The field bit alternates from frame to frame, and only the source lines whose index parity matches the field are emitted. The other lines produce no output. In progressive mode every line is emitted with the field bit at 0. A standard-select input picks the 525-line or 625-line set of constants: the number of leading vertical-blanking lines and the length of the horizontal blanking fill.

Input contract: the line marker is a one-cycle pulse, and the frame marker is raised together with the line marker of line 0. The first pixel of a line comes no earlier than two cycles after its line marker. Pixels come at most one every two cycles. The next line marker comes only after the previous line's fill has been sent.

Top module: `fld656_formatter`

## Requirements
- R1: After reset, out_stb is 0, out_byte is 00h and out_field is 0.
- R2: An emitted line begins with the bytes FFh, 00h, 00h and a status byte whose H bit is 0. The FFh byte is presented on the clock edge that samples the line marker, and the remaining bytes follow on consecutive cycles.
- R3: The status byte is laid out as {1, F, V, H, V^H, F^H, F^V, F^V^H}, with bit 7 first. H is 1 in the end code that follows the last pixel.
- R4: Each pixel pair (p0, p1) is emitted as Cb, Y(p0), Cr, Y(p1). Y = floor((66R+129G+25B+128)/256)+16, Cb = floor((-38R-74G+112B+128)/256)+128 and Cr = floor((112R-94G-18B+128)/256)+128. The pair's Cb and Cr are floor((c0+c1)/2).
- R5: Active luma is limited to 16..235 and active chroma to 16..240, so the values 00h and FFh never appear in active video.
- R6: After the last of ACT_PIX pixels, the end code is sent. It is followed by FILL_525 (standard select 0) or FILL_625 (standard select 1) groups of the bytes 80h, 10h, 80h, 10h, with no idle cycle between groups.
- R7: Lines whose index within the frame is below VB_525 or VB_625 (chosen by standard select) carry V=1. Their active region is filled with 80h/10h regardless of the pixel values supplied.
- R8: In interlaced mode, a line whose index parity differs from the current field emits no bytes. Its pixels are ignored.
- R9: In interlaced mode the first frame after reset is field 0, and each later frame flips the field. In progressive mode F and out_field are 0. out_field changes only at a frame start.
- R10: Pixels that arrive outside the active window of an emitted line produce no output bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_rgb | input | 24 | Pixel, R in [23:16], G in [15:8], B in [7:0] |
| pix_vld | input | 1 | Pixel valid strobe |
| sol | input | 1 | Start-of-line pulse |
| sof | input | 1 | Start-of-frame, qualified by sol |
| std625 | input | 1 | 0 selects 525-line constants, 1 selects 625-line |
| ilace_en | input | 1 | 1 selects interlaced output |
| out_byte | output | 8 | Multiplexed output byte |
| out_stb | output | 1 | out_byte carries a valid byte |
| out_field | output | 1 | Field of the frame in progress |

## Verification
Two events can coincide on the same clock edge. The last pixel of a line completes its pair and loads that quad, while the same pixel also arms the end-code sequencer. In the same way, the frame marker flips the field while the start code of line 0 is being built from that new field. The bench provokes both on every line and every frame by feeding pixels at the fastest legal rate. It then compares the byte stream word for word against an independently computed sequence, which shows the end code right after the last pair with no gap or overlap. It also checks that the line-0 status byte carries the new field value and not the old one.

// File: rtl/fmt656_pkg.sv
package fmt656_pkg;

  typedef struct packed {
    logic [7:0] y;
    logic [7:0] cb;
    logic [7:0] cr;
  } ycc_t;

  localparam logic [31:0] FILL_QUAD = 32'h8010_8010;

  function automatic logic [7:0] clip8(input int v, input int lo, input int hi);
    if (v < lo)      return 8'(lo);
    else if (v > hi) return 8'(hi);
    else             return 8'(v);
  endfunction

  function automatic ycc_t rgb_to_ycc(input logic [23:0] rgb);
    int r, g, b;
    ycc_t o;
    r = int'(rgb[23:16]);
    g = int'(rgb[15:8]);
    b = int'(rgb[7:0]);
    o.y  = clip8(((66 * r + 129 * g + 25 * b + 128) >>> 8) + 16, 16, 235);
    o.cb = clip8(((-38 * r - 74 * g + 112 * b + 128) >>> 8) + 128, 16, 240);
    o.cr = clip8(((112 * r - 94 * g - 18 * b + 128) >>> 8) + 128, 16, 240);
    return o;
  endfunction

  function automatic logic [7:0] avg8(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[8:1];
  endfunction

  function automatic logic [31:0] trs_word(input logic f, input logic v, input logic h);
    return {8'hFF, 8'h00, 8'h00, 1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

endpackage

// File: rtl/ycc_conv.sv
module ycc_conv
  import fmt656_pkg::*;
(
  input  logic [23:0] rgb,
  output ycc_t        ycc
);
  assign ycc = rgb_to_ycc(rgb);
endmodule

// File: rtl/line_seq.sv
module line_seq #(
  parameter int LINE_W = 10,
  parameter int VB_525 = 19,
  parameter int VB_625 = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sol,
  input  logic sof,
  input  logic std625,
  input  logic ilace_en,
  output logic keep_start,
  output logic cur_f,
  output logic cur_v,
  output logic field
);
  localparam logic [LINE_W-1:0] VB5 = LINE_W'(VB_525);
  localparam logic [LINE_W-1:0] VB6 = LINE_W'(VB_625);

  logic [LINE_W-1:0] lcnt, cur_idx;
  logic              fld_r, nxt_r, frame_go;

  assign frame_go = sol & sof;

  always_comb begin
    cur_idx = frame_go ? '0 : lcnt + 1'b1;
    cur_f   = frame_go ? (ilace_en & nxt_r) : fld_r;
    cur_v   = std625 ? (cur_idx < VB6) : (cur_idx < VB5);
  end

  assign keep_start = sol & (~ilace_en | (cur_idx[0] == cur_f));
  assign field      = fld_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcnt  <= '0;
      fld_r <= 1'b0;
      nxt_r <= 1'b0;
    end else begin
      if (sol) lcnt <= cur_idx;
      if (frame_go) begin
        fld_r <= ilace_en & nxt_r;
        nxt_r <= ilace_en & ~nxt_r;
      end
    end
  end
endmodule

// File: rtl/byte_ser.sv
module byte_ser (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld,
  input  logic [31:0] ld_word,
  output logic [7:0]  out_byte,
  output logic        out_stb,
  output logic        busy
);
  logic [23:0] rest;
  logic [1:0]  left;

  assign busy = (left != 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rest     <= '0;
      left     <= '0;
      out_byte <= '0;
      out_stb  <= 1'b0;
    end else if (ld) begin
      out_byte <= ld_word[31:24];
      out_stb  <= 1'b1;
      rest     <= ld_word[23:0];
      left     <= 2'd3;
    end else if (busy) begin
      out_byte <= rest[23:16];
      out_stb  <= 1'b1;
      rest     <= {rest[15:0], 8'h00};
      left     <= left - 2'd1;
    end else begin
      out_stb  <= 1'b0;
    end
  end
endmodule

// File: rtl/fld656_formatter.sv
module fld656_formatter
  import fmt656_pkg::*;
#(
  parameter int ACT_PIX  = 720,
  parameter int FILL_525 = 67,
  parameter int FILL_625 = 70,
  parameter int VB_525   = 19,
  parameter int VB_625   = 22,
  parameter int LINE_W   = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] pix_rgb,
  input  logic        pix_vld,
  input  logic        sol,
  input  logic        sof,
  input  logic        std625,
  input  logic        ilace_en,
  output logic [7:0]  out_byte,
  output logic        out_stb,
  output logic        out_field
);
  localparam int PIX_W    = $clog2(ACT_PIX);
  localparam int FILL_MAX = (FILL_625 > FILL_525) ? FILL_625 : FILL_525;
  localparam int FILL_W   = $clog2(FILL_MAX + 1);

  logic              keep_start, cur_f, cur_v;
  logic              act, vln, fln, eav_pend;
  logic [PIX_W-1:0]  pcnt;
  logic [FILL_W-1:0] fill_left, fill_sel;
  ycc_t              px, px0;
  logic              take_pix, pair_ld, last_pix, tail_ld, ld, ser_busy;
  logic [31:0]       ld_word;

  line_seq #(.LINE_W(LINE_W), .VB_525(VB_525), .VB_625(VB_625)) u_lines (
    .clk, .rst_n, .sol, .sof, .std625, .ilace_en,
    .keep_start, .cur_f, .cur_v, .field(out_field)
  );

  ycc_conv u_conv (.rgb(pix_rgb), .ycc(px));

  assign take_pix = pix_vld & act & ~sol;
  assign pair_ld  = take_pix & pcnt[0];
  assign last_pix = take_pix & (pcnt == PIX_W'(ACT_PIX - 1));
  assign tail_ld  = ~keep_start & ~pair_ld & ~ser_busy & (eav_pend | (fill_left != '0));
  assign ld       = keep_start | pair_ld | tail_ld;

  always_comb begin
    if (keep_start)   ld_word = trs_word(cur_f, cur_v, 1'b0);
    else if (pair_ld) ld_word = vln ? FILL_QUAD
                              : {avg8(px0.cb, px.cb), px0.y, avg8(px0.cr, px.cr), px.y};
    else if (eav_pend) ld_word = trs_word(fln, vln, 1'b1);
    else              ld_word = FILL_QUAD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act       <= 1'b0;
      vln       <= 1'b0;
      fln       <= 1'b0;
      eav_pend  <= 1'b0;
      pcnt      <= '0;
      fill_left <= '0;
      fill_sel  <= '0;
      px0       <= '0;
    end else if (keep_start) begin
      act       <= 1'b1;
      pcnt      <= '0;
      vln       <= cur_v;
      fln       <= cur_f;
      eav_pend  <= 1'b0;
      fill_left <= '0;
      fill_sel  <= std625 ? FILL_W'(FILL_625) : FILL_W'(FILL_525);
    end else begin
      if (sol) act <= 1'b0;
      if (take_pix) begin
        pcnt <= pcnt + 1'b1;
        if (!pcnt[0]) px0 <= px;
        if (last_pix) begin
          act      <= 1'b0;
          eav_pend <= 1'b1;
        end
      end
      if (tail_ld) begin
        if (eav_pend) begin
          eav_pend  <= 1'b0;
          fill_left <= fill_sel;
        end else begin
          fill_left <= fill_left - 1'b1;
        end
      end
    end
  end

  byte_ser u_ser (
    .clk, .rst_n, .ld, .ld_word, .out_byte, .out_stb, .busy(ser_busy)
  );
endmodule

// File: rtl/fmt656_chk.sv
module fmt656_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sol,
  input logic       sof,
  input logic       ilace_en,
  input logic [7:0] out_byte,
  input logic       out_stb,
  input logic       out_field,
  input logic       ld,
  input logic       ser_busy
);
  logic [7:0] h1, h2, h3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h1 <= '0;
      h2 <= '0;
      h3 <= '0;
    end else if (out_stb) begin
      h3 <= h2;
      h2 <= h1;
      h1 <= out_byte;
    end
  end

  assert_quad_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> !ser_busy);

  assert_ff_only_in_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stb && out_byte == 8'hFF) |=> (out_stb && out_byte == 8'h00));

  assert_status_layout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stb && h3 == 8'hFF && h2 == 8'h00 && h1 == 8'h00) |->
      (out_byte[7] && out_byte[3:0] == {out_byte[5] ^ out_byte[4], out_byte[6] ^ out_byte[4],
                                        out_byte[6] ^ out_byte[5], ^out_byte[6:4]}));

  assert_field_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sol && sof) |=> $stable(out_field));

  assert_prog_field_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sol && sof && !ilace_en) |=> !out_field);
endmodule

bind fld656_formatter fmt656_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sol(sol), .sof(sof), .ilace_en(ilace_en),
  .out_byte(out_byte), .out_stb(out_stb), .out_field(out_field),
  .ld(ld), .ser_busy(ser_busy)
);

// File: tb/fld656_formatter_tb.sv
module fld656_formatter_tb;
  localparam int AP = 4;
  localparam int F5 = 1;
  localparam int F6 = 2;
  localparam int V5 = 1;
  localparam int V6 = 2;
  localparam logic [23:0] VEC [8] = '{24'h000000, 24'hFFFFFF, 24'hFF0000, 24'h00FF00,
                                      24'h0000FF, 24'h808080, 24'h123456, 24'hFEDCBA};

  logic clk = 0, rst_n = 0;
  logic [23:0] pix_rgb = '0;
  logic pix_vld = 0, sol = 0, sof = 0, std625 = 0, ilace_en = 0;
  logic [7:0] out_byte;
  logic out_stb, out_field;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] exp_b[$];
  string exp_t[$];
  int b_line = 0;
  bit b_fld = 0, b_nxt = 0;

  always #5 clk = ~clk;

  fld656_formatter #(.ACT_PIX(AP), .FILL_525(F5), .FILL_625(F6), .VB_525(V5), .VB_625(V6))
    u_dut (.clk, .rst_n, .pix_rgb, .pix_vld, .sol, .sof, .std625, .ilace_en,
           .out_byte, .out_stb, .out_field);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int fl256(input int x);
    if (x >= 0) return x / 256;
    return -((-x + 255) / 256);
  endfunction

  function automatic int lim(input int v, input int lo, input int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  function automatic int m_y(input logic [23:0] c);
    return lim(16 + fl256(128 + 25 * c[7:0] + 129 * c[15:8] + 66 * c[23:16]), 16, 235);
  endfunction
  function automatic int m_cb(input logic [23:0] c);
    return lim(128 + fl256(128 + 112 * c[7:0] - 74 * c[15:8] - 38 * c[23:16]), 16, 240);
  endfunction
  function automatic int m_cr(input logic [23:0] c);
    return lim(128 + fl256(128 - 18 * c[7:0] - 94 * c[15:8] + 112 * c[23:16]), 16, 240);
  endfunction

  task automatic push(input int b, input string t);
    exp_b.push_back(8'(b));
    exp_t.push_back(t);
  endtask

  task automatic push_code(input bit f, input bit v, input bit h, input string t);
    int xy;
    xy = 128 + 64 * f + 32 * v + 16 * h + 8 * (v != h) + 4 * (f != h) + 2 * (f != v)
         + ((f + v + h) % 2);
    push(255, t); push(0, t); push(0, t); push(xy, "R3");
  endtask

  always @(negedge clk) begin
    if (rst_n && out_stb) begin
      if (exp_b.size() == 0) chk(0, "R10", out_byte, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_b.pop_front();
        t = exp_t.pop_front();
        chk(out_byte == e, t, out_byte, e);
        if (t == "R4") chk(out_byte != 8'h00 && out_byte != 8'hFF, "R5", out_byte, 8'h80);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stray_pix(input int n);
    for (int i = 0; i < n; i++) begin
      pix_rgb = 24'hFFFFFF; pix_vld = 1; @(negedge clk);
      pix_vld = 0; @(negedge clk);
    end
  endtask

  task automatic do_line(input bit fs, input logic [23:0] p [4]);
    bit kept, vb;
    if (fs) begin
      b_line = 0;
      b_fld = ilace_en & b_nxt;
      b_nxt = ilace_en & ~b_nxt;
    end else b_line++;
    kept = !ilace_en || ((b_line % 2) == b_fld);
    vb = b_line < (std625 ? V6 : V5);
    if (kept) begin
      push_code(b_fld, vb, 0, "R2");
      for (int k = 0; k < AP; k += 2) begin
        if (vb) begin
          push(128, "R7"); push(16, "R7"); push(128, "R7"); push(16, "R7");
        end else begin
          push((m_cb(p[k]) + m_cb(p[k+1])) / 2, "R4");
          push(m_y(p[k]), "R4");
          push((m_cr(p[k]) + m_cr(p[k+1])) / 2, "R4");
          push(m_y(p[k+1]), "R4");
        end
      end
      push_code(b_fld, vb, 1, "R6");
      for (int q = 0; q < (std625 ? F6 : F5); q++) begin
        push(128, "R6"); push(16, "R6"); push(128, "R6"); push(16, "R6");
      end
    end
    sol = 1; sof = fs; @(negedge clk);
    sol = 0; sof = 0;
    if (kept) chk(out_stb == 1 && out_byte == 8'hFF, "R2", {out_stb, out_byte}, 9'h1FF);
    if (fs) chk(out_field == b_fld, "R9", out_field, b_fld);
    @(negedge clk);
    for (int k = 0; k < AP; k++) begin
      pix_rgb = p[k]; pix_vld = 1; @(negedge clk);
      pix_vld = 0; @(negedge clk);
    end
    idle(4 * F6 + 12);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] a [4];
    logic [23:0] b [4];
    idle(3);
    chk(out_stb == 0 && out_byte == 0 && out_field == 0, "R1",
        {out_stb, out_field, out_byte}, 0);
    rst_n = 1;
    idle(2);

    // R4 table walk, progressive 525 (line 0 is vertical blanking, R7)
    for (int v = 0; v < 8; v += AP) begin
      for (int k = 0; k < AP; k++) a[k] = VEC[v + k];
      if (v == 0) do_line(1, a);
      do_line(0, a);
    end
    stray_pix(3);   // R10: pixels with no line open
    idle(6);

    // 625 progressive: two blanking lines, longer fill (R6, R7)
    std625 = 1;
    for (int k = 0; k < AP; k++) begin
      a[k] = VEC[7 - k];
      b[k] = {8'(k * 40), 8'(200 - k * 30), 8'(k * 60 + 10)};
    end
    do_line(1, b);
    do_line(0, b);
    do_line(0, a);
    stray_pix(2);   // R10 after active window closed
    idle(6);

    // Interlaced 525: three frames, fields 0, 1, 0 (R8, R9)
    std625 = 0;
    ilace_en = 1;
    for (int fr = 0; fr < 3; fr++) begin
      do_line(1, a);
      for (int l = 1; l < 4; l++) do_line(0, (l % 2) ? b : a);
    end
    // back to progressive: field must return to 0 (R9)
    ilace_en = 0;
    do_line(1, a);
    do_line(0, b);
    idle(10);

    chk(exp_b.size() == 0, "R8", exp_b.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule